// File: doc/BRIEF.md
# Small Register Processor Core

This block is a compact single-issue processor. Each cycle it fetches one 16-bit instruction from an internal instruction store, decodes it, runs it against a sixteen-entry register file and an internal data store, and writes back before the next fetch. The instruction set covers four groups. Data movement loads a word from memory, stores a register to memory, or copies one register to another. Arithmetic and logic instructions add, subtract, AND or OR two registers into a third. Branches jump unconditionally, or jump on a zero or negative result. Control instructions are no-operation and halt.

Conditional branches do not compare registers. They test two flags taken from the most recent arithmetic or logic result. A halt instruction freezes the machine until the next reset. Both stores are plain arrays, written through a side port while the core is held in reset. The data store can also be read through that port, so results can be seen from outside.

Instruction word: bits [15:12] opcode, [11:8] first register field, [7:4] second register field, [3:0] third register field. Memory and branch forms put an 8-bit address in [7:0].

Top module: `reg_cpu`

## Requirements
- R1: While rst_ni is low, pc_o reads 0 and halted_o reads 0, both flags are cleared, and all registers read as zero once running.
- R2: Opcode 0x1 (LOAD) copies data word [7:0] into register [11:8]. Opcode 0x2 (STORE) writes register [11:8] to data word [7:0]. Neither changes the flags.
- R3: Opcode 0x3 (MOVE) copies register [7:4] into register [11:8].
- R4: Opcodes 0x4 ADD, 0x5 SUB, 0x6 AND and 0x7 OR write reg[11:8] = reg[7:4] op reg[3:0], modulo 2^DATA_W.
- R5: Only opcodes 0x4 to 0x7 update the flags. zero is set when the result is all zeros, and neg is the result's MSB. All other instructions keep both flags.
- R6: Opcode 0x8 loads the PC with field [7:0] unconditionally.
- R7: Opcode 0x9 branches to [7:0] only when zero is set. Opcode 0xA branches only when neg is set. Otherwise the PC advances by one.
- R8: Opcode 0x0 (NOP) writes no register or memory, keeps the flags, and advances the PC by one. Every other non-branch instruction also advances the PC by one.
- R9: Opcode 0xF (HALT) sets halted_o. From then on the PC stays at the halt address and no register, memory or flag changes until reset.
- R10: A write through the external port (imem_we_i, dmem_we_i) lands at its address on the next rising clock edge. dmem_rdata_o shows the data word at dmem_addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_we_i | input | 1 | Instruction store write enable |
| imem_addr_i | input | 8 | Instruction store write address |
| imem_wdata_i | input | 16 | Instruction word to write |
| dmem_we_i | input | 1 | Data store external write enable |
| dmem_addr_i | input | 8 | Data store external address (read and write) |
| dmem_wdata_i | input | DATA_W | Data word to write |
| dmem_rdata_o | output | DATA_W | Data word at dmem_addr_i |
| pc_o | output | 8 | Current program counter |
| halted_o | output | 1 | Machine has executed HALT |

## Verification
The assertions assume that the instruction store does not change while the core runs. They also assume that the external write ports stay idle outside reset, because an external data write would race the core's own store. The bench meets both conditions. It loads the program once and preloads data words only with rst_ni low. It then releases reset and does nothing but observe until halted_o rises. It sweeps every pair drawn from a set of edge operands (0, 1, small, mid, max positive, min negative, all ones). This drives each flag both ways through the conditional branches.

// File: rtl/rcpu_pkg.sv
`timescale 1ns/1ps
package rcpu_pkg;
  localparam int INSTR_W = 16;
  localparam int OP_W    = 4;
  localparam int REG_AW  = 4;
  localparam int ADDR_W  = 8;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_MOVE  = 4'h3,
    OP_ADD   = 4'h4,
    OP_SUB   = 4'h5,
    OP_AND   = 4'h6,
    OP_OR    = 4'h7,
    OP_JMP   = 4'h8,
    OP_JZ    = 4'h9,
    OP_JN    = 4'hA,
    OP_HALT  = 4'hF
  } op_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_REG} wb_sel_e;

  typedef struct packed {
    logic    rf_we;
    wb_sel_e wb_sel;
    logic    mem_we;
    logic    flag_we;
    alu_op_e alu_op;
    logic    jmp;
    logic    jz;
    logic    jn;
    logic    halt;
  } ctrl_t;
endpackage

// File: rtl/rcpu_ram.sv
`timescale 1ns/1ps
module rcpu_ram #(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int N_RD = 1
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        waddr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [N_RD-1:0][AW-1:0] raddr_i,
  output logic [N_RD-1:0][DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar i = 0; i < N_RD; i++) begin : g_rd
    assign rdata_o[i] = mem_q[raddr_i[i]];
  end
endmodule

// File: rtl/rcpu_regfile.sv
`timescale 1ns/1ps
module rcpu_regfile #(
  parameter int AW   = 4,
  parameter int DW   = 16,
  parameter int N_RD = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [N_RD-1:0][AW-1:0] raddr_i,
  output logic [N_RD-1:0][DW-1:0] rdata_o
);
  localparam int N_REGS = 1 << AW;

  logic [DW-1:0] regs_q [N_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_REGS; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar i = 0; i < N_RD; i++) begin : g_rd
    assign rdata_o[i] = regs_q[raddr_i[i]];
  end
endmodule

// File: rtl/rcpu_decode.sv
`timescale 1ns/1ps
module rcpu_decode
  import rcpu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o = '{rf_we: 1'b0, wb_sel: WB_ALU, mem_we: 1'b0, flag_we: 1'b0,
               alu_op: ALU_ADD, jmp: 1'b0, jz: 1'b0, jn: 1'b0, halt: 1'b0};
    case (op_e'(op_i))
      OP_LOAD:  begin ctrl_o.rf_we = 1'b1; ctrl_o.wb_sel = WB_MEM; end
      OP_STORE: ctrl_o.mem_we = 1'b1;
      OP_MOVE:  begin ctrl_o.rf_we = 1'b1; ctrl_o.wb_sel = WB_REG; end
      OP_ADD:   begin ctrl_o.rf_we = 1'b1; ctrl_o.flag_we = 1'b1; ctrl_o.alu_op = ALU_ADD; end
      OP_SUB:   begin ctrl_o.rf_we = 1'b1; ctrl_o.flag_we = 1'b1; ctrl_o.alu_op = ALU_SUB; end
      OP_AND:   begin ctrl_o.rf_we = 1'b1; ctrl_o.flag_we = 1'b1; ctrl_o.alu_op = ALU_AND; end
      OP_OR:    begin ctrl_o.rf_we = 1'b1; ctrl_o.flag_we = 1'b1; ctrl_o.alu_op = ALU_OR;  end
      OP_JMP:   ctrl_o.jmp  = 1'b1;
      OP_JZ:    ctrl_o.jz   = 1'b1;
      OP_JN:    ctrl_o.jn   = 1'b1;
      OP_HALT:  ctrl_o.halt = 1'b1;
      default:  ; // NOP and unassigned codes: no state change
    endcase
  end
endmodule

// File: rtl/rcpu_alu.sv
`timescale 1ns/1ps
module rcpu_alu
  import rcpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      default: y_o = a_i | b_i;
    endcase
  end
endmodule

// File: rtl/reg_cpu.sv
`timescale 1ns/1ps
module reg_cpu
  import rcpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              imem_we_i,
  input  logic [ADDR_W-1:0] imem_addr_i,
  input  logic [INSTR_W-1:0] imem_wdata_i,
  input  logic              dmem_we_i,
  input  logic [ADDR_W-1:0] dmem_addr_i,
  input  logic [DATA_W-1:0] dmem_wdata_i,
  output logic [DATA_W-1:0] dmem_rdata_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              halted_o
);
  localparam int RF_RD = 3;

  logic [ADDR_W-1:0]  pc_q, pc_d;
  logic               zero_q, neg_q, halted_q;
  logic [INSTR_W-1:0] instr;
  ctrl_t              ctrl;
  logic               run, take;

  logic [OP_W-1:0]   f_op;
  logic [REG_AW-1:0] f_r1, f_r2, f_r3;
  logic [ADDR_W-1:0] f_addr;

  logic [RF_RD-1:0][REG_AW-1:0] rf_raddr;
  logic [RF_RD-1:0][DATA_W-1:0] rf_rdata;
  logic [DATA_W-1:0] alu_y, wb_data;

  logic [1:0][ADDR_W-1:0] dm_raddr;
  logic [1:0][DATA_W-1:0] dm_rdata;
  logic [0:0][ADDR_W-1:0] im_raddr;
  logic [0:0][INSTR_W-1:0] im_rdata;
  logic               dm_we;
  logic [ADDR_W-1:0]  dm_waddr;
  logic [DATA_W-1:0]  dm_wdata;

  // fetch
  assign im_raddr[0] = pc_q;
  rcpu_ram #(.AW(ADDR_W), .DW(INSTR_W), .N_RD(1)) u_imem (
    .clk_i, .we_i(imem_we_i), .waddr_i(imem_addr_i), .wdata_i(imem_wdata_i),
    .raddr_i(im_raddr), .rdata_o(im_rdata)
  );
  assign instr = im_rdata[0];

  // fields
  assign f_op   = instr[15:12];
  assign f_r1   = instr[11:8];
  assign f_r2   = instr[7:4];
  assign f_r3   = instr[3:0];
  assign f_addr = instr[7:0];

  rcpu_decode u_dec (.op_i(f_op), .ctrl_o(ctrl));

  assign run = !halted_q;

  // register file: port 0/1 ALU operands, port 2 store source
  assign rf_raddr[0] = f_r2;
  assign rf_raddr[1] = f_r3;
  assign rf_raddr[2] = f_r1;
  rcpu_regfile #(.AW(REG_AW), .DW(DATA_W), .N_RD(RF_RD)) u_rf (
    .clk_i, .rst_ni, .we_i(ctrl.rf_we && run), .waddr_i(f_r1), .wdata_i(wb_data),
    .raddr_i(rf_raddr), .rdata_o(rf_rdata)
  );

  rcpu_alu #(.DW(DATA_W)) u_alu (
    .op_i(ctrl.alu_op), .a_i(rf_rdata[0]), .b_i(rf_rdata[1]), .y_o(alu_y)
  );

  // data store: port 0 core, port 1 external view; external write wins
  assign dm_raddr[0] = f_addr;
  assign dm_raddr[1] = dmem_addr_i;
  assign dm_we    = dmem_we_i || (ctrl.mem_we && run && rst_ni);
  assign dm_waddr = dmem_we_i ? dmem_addr_i  : f_addr;
  assign dm_wdata = dmem_we_i ? dmem_wdata_i : rf_rdata[2];
  rcpu_ram #(.AW(ADDR_W), .DW(DATA_W), .N_RD(2)) u_dmem (
    .clk_i, .we_i(dm_we), .waddr_i(dm_waddr), .wdata_i(dm_wdata),
    .raddr_i(dm_raddr), .rdata_o(dm_rdata)
  );
  assign dmem_rdata_o = dm_rdata[1];

  always_comb begin
    case (ctrl.wb_sel)
      WB_MEM:  wb_data = dm_rdata[0];
      WB_REG:  wb_data = rf_rdata[0];
      default: wb_data = alu_y;
    endcase
  end

  // next PC
  assign take = ctrl.jmp || (ctrl.jz && zero_q) || (ctrl.jn && neg_q);
  always_comb begin
    if (!run || ctrl.halt) pc_d = pc_q;
    else if (take)         pc_d = f_addr;
    else                   pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      zero_q   <= 1'b0;
      neg_q    <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (run && ctrl.flag_we) begin
        zero_q <= (alu_y == '0);
        neg_q  <= alu_y[DATA_W-1];
      end
      if (run && ctrl.halt) halted_q <= 1'b1;
    end
  end

  assign pc_o     = pc_q;
  assign halted_o = halted_q;
endmodule

// File: rtl/reg_cpu_checker.sv
`timescale 1ns/1ps
module reg_cpu_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] pc_o,
  input logic       halted_o,
  input logic [3:0] op,
  input logic [7:0] target,
  input logic       zero,
  input logic       neg
);
  a_r9_halt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'hF && !halted_o) |=> halted_o);

  a_r9_halt_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(pc_o) && $stable(zero) && $stable(neg)));

  a_r6_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'h8 && !halted_o) |=> (pc_o == $past(target)));

  a_r7_jz_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'h9 && zero && !halted_o) |=> (pc_o == $past(target)));

  a_r7_jn_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'hA && !neg && !halted_o) |=> (pc_o == $past(pc_o) + 8'd1));

  a_r5_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(op inside {4'h4, 4'h5, 4'h6, 4'h7})) |=> ($stable(zero) && $stable(neg)));

  a_r8_nop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 4'h0 && !halted_o) |=> (pc_o == $past(pc_o) + 8'd1));

  a_r1_reset_pc: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_o == 8'd0 && !halted_o));
endmodule

bind reg_cpu reg_cpu_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pc_o(pc_o), .halted_o(halted_o),
  .op(instr[15:12]), .target(instr[7:0]), .zero(zero_q), .neg(neg_q)
);

// File: tb/reg_cpu_test.sv
`timescale 1ns/1ps
module reg_cpu_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        imem_we_i = 1'b0;
  logic [7:0]  imem_addr_i = '0;
  logic [15:0] imem_wdata_i = '0;
  logic        dmem_we_i = 1'b0;
  logic [7:0]  dmem_addr_i = '0;
  logic [15:0] dmem_wdata_i = '0;
  logic [15:0] dmem_rdata_o;
  logic [7:0]  pc_o;
  logic        halted_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  reg_cpu uut (.*);

  function automatic logic [15:0] enc_r(input logic [3:0] op, rd, ra, rb);
    return {op, rd, ra, rb};
  endfunction
  function automatic logic [15:0] enc_i(input logic [3:0] op, r, input logic [7:0] a);
    return {op, r, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_i(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i);
    imem_we_i = 1'b1; imem_addr_i = a; imem_wdata_i = d;
    @(negedge clk_i);
    imem_we_i = 1'b0;
  endtask

  task automatic wr_d(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i);
    dmem_we_i = 1'b1; dmem_addr_i = a; dmem_wdata_i = d;
    @(negedge clk_i);
    dmem_we_i = 1'b0;
  endtask

  task automatic rd_d(input logic [7:0] a, output logic [15:0] d);
    dmem_addr_i = a;
    #1;
    d = dmem_rdata_o;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] vals [7];
    logic [15:0] rd;
    int cyc, exp_cyc;
    logic [15:0] a, b, diff;
    vals = '{16'h0000, 16'h0001, 16'h0005, 16'h1234, 16'h7FFF, 16'h8000, 16'hFFFF};

    // program (R2, R3, R4, R5, R6, R7, R8, R9)
    wr_i(8'd0,  enc_i(4'h1, 4'd1, 8'd0));
    wr_i(8'd1,  enc_i(4'h1, 4'd2, 8'd1));
    wr_i(8'd2,  enc_r(4'h4, 4'd3, 4'd1, 4'd2));
    wr_i(8'd3,  enc_i(4'h2, 4'd3, 8'd16));
    wr_i(8'd4,  enc_r(4'h5, 4'd4, 4'd1, 4'd2));
    wr_i(8'd5,  enc_i(4'h2, 4'd4, 8'd17));
    wr_i(8'd6,  enc_r(4'h6, 4'd5, 4'd1, 4'd2));
    wr_i(8'd7,  enc_i(4'h2, 4'd5, 8'd18));
    wr_i(8'd8,  enc_r(4'h7, 4'd6, 4'd1, 4'd2));
    wr_i(8'd9,  enc_i(4'h2, 4'd6, 8'd19));
    wr_i(8'd10, enc_r(4'h3, 4'd7, 4'd1, 4'd0));
    wr_i(8'd11, enc_i(4'h2, 4'd7, 8'd20));
    wr_i(8'd12, enc_r(4'h5, 4'd0, 4'd1, 4'd2));
    wr_i(8'd13, 16'h0000);
    wr_i(8'd14, enc_i(4'h1, 4'd8, 8'd2));
    wr_i(8'd15, enc_i(4'h9, 4'd0, 8'd18));
    wr_i(8'd16, enc_i(4'h2, 4'd8, 8'd21));
    wr_i(8'd17, 16'h0000);
    wr_i(8'd18, enc_i(4'hA, 4'd0, 8'd20));
    wr_i(8'd19, enc_i(4'h2, 4'd8, 8'd22));
    wr_i(8'd20, enc_i(4'h8, 4'd0, 8'd22));
    wr_i(8'd21, enc_i(4'h2, 4'd8, 8'd23));
    wr_i(8'd22, enc_i(4'h2, 4'd15, 8'd24));
    wr_i(8'd23, 16'hF000);
    wr_i(8'd24, enc_i(4'h2, 4'd8, 8'd25));

    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < 7; j++) begin
        a = vals[i]; b = vals[j]; diff = a - b;
        @(negedge clk_i);
        rst_ni = 1'b0;
        wr_d(8'd0, a);
        wr_d(8'd1, b);
        wr_d(8'd2, 16'h0001);
        for (int k = 16; k <= 23; k++) wr_d(8'(k), (k >= 21) ? 16'h0000 : 16'hDEAD);
        wr_d(8'd24, 16'h5A5A);
        wr_d(8'd25, 16'h1234);
        chk("R1 reset pc", 32'(pc_o), 32'd0);
        chk("R1 reset halted", 32'(halted_o), 32'd0);
        rd_d(8'd1, rd);
        chk("R10 preload readback", 32'(rd), 32'(b));

        @(negedge clk_i);
        rst_ni = 1'b1;
        cyc = 0;
        while (!halted_o && cyc < 200) begin
          @(negedge clk_i);
          cyc++;
        end
        exp_cyc = 16 + ((a == b) ? 0 : 2) + 1 + (diff[15] ? 0 : 1) + 3;
        chk("R8 R7 executed instruction count", 32'(cyc), 32'(exp_cyc));
        repeat (4) @(negedge clk_i);
        chk("R9 halted held", 32'(halted_o), 32'd1);
        chk("R9 pc frozen", 32'(pc_o), 32'd23);

        rd_d(8'd16, rd); chk("R4 add", 32'(rd), 32'(16'(a + b)));
        rd_d(8'd17, rd); chk("R4 sub", 32'(rd), 32'(diff));
        rd_d(8'd18, rd); chk("R4 and", 32'(rd), 32'(a & b));
        rd_d(8'd19, rd); chk("R4 or",  32'(rd), 32'(a | b));
        rd_d(8'd20, rd); chk("R3 R2 move/load/store", 32'(rd), 32'(a));
        rd_d(8'd21, rd); chk("R7 R5 zero branch", 32'(rd), (a == b) ? 32'd0 : 32'd1);
        rd_d(8'd22, rd); chk("R7 R5 neg branch", 32'(rd), diff[15] ? 32'd0 : 32'd1);
        rd_d(8'd23, rd); chk("R6 jump skips", 32'(rd), 32'd0);
        rd_d(8'd24, rd); chk("R1 register cleared", 32'(rd), 32'd0);
        rd_d(8'd25, rd); chk("R9 nothing after halt", 32'(rd), 32'h1234);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule